// File: doc/BRIEF.md
# SPI Target with Early Receive Match

This block is the target side of an SPI link running in mode 0. An external controller drives chip select and the serial clock. The block shifts each frame in on MOSI and, in the same bit periods, shifts the loaded reply out on MISO. The frame length is programmable from 1 to 64 bits. Frames longer than 32 bits are carried as several words: every word holds 32 bits except the last, which holds what remains.

Transmit words come from a small FIFO and received words go into another. Each received word is compared with two programmable values. A hit raises a sticky match flag and, if enabled, the interrupt. The compare happens as soon as the word ends, so after the first frame of a transaction host logic can react and push a reply. That reply then goes out in a later frame of the same chip-select period. Status flags cover word end, frame end, transmit underrun, data match and receive overflow.

The host side is a simple register port with a combinational read. Register map by `reg_addr`:
- 0 control: frame length minus one in [5:0], match mode in [9:8].
- 1 interrupt enable: bit layout as in status.
- 2 status: flags and FIFO levels.
- 3 first compare value.
- 4 second compare value.
- 5 transmit push (write only).
- 6 receive pop (read only).

Top module: `spi_tgt_match`

## Requirements
- R1: After reset the status register reads 0 (no flags, both FIFO levels 0), the control register reads 7 (8-bit frames, match off), and `miso` and `irq` are 0.
- R2: The bus is mode 0, MSB first. MOSI is sampled on the rising `sck` edge and MISO changes after the falling edge. The first bit is valid on MISO before the first rising edge after `cs_n` falls. Each completed received word is pushed into the receive FIFO, right-justified, and is read and popped at address 6.
- R3: The transmit FIFO holds 4 words. A push to a full FIFO is discarded. The level is shown in status [10:8]. The head word is taken at `cs_n` assertion. Later words are taken at the first rising edge of their word, so a read between frames shows the entries still waiting.
- R4: If the transmit FIFO is empty at `cs_n` assertion, or at the start of a later word, status bit 2 sets and MISO drives zeros for the rest of that frame. No FIFO entry is consumed.
- R5: A frame is control[5:0]+1 bits long. It is cut into 32-bit words with a shorter final word. Status bit 0 sets at the end of every word, and bit 1 only at the end of the last word of a frame.
- R6: Match mode control[9:8] selects the compare. 0 is off. 1 hits when a word equals value A or value B. 2 is the same as 1 but only for the first word after `cs_n` assertion. 3 hits when the word equals A on the bits set in B. Only the word's own low bits take part. A hit sets status bit 3 at the end of that word.
- R7: A word pushed after the match of the first frame, and before the next falling `sck` edge, is sent as the next frame of the same transaction.
- R8: The receive FIFO holds 4 words. A word that completes while it is full is dropped and sets status bit 4.
- R9: Status flags are write-one-to-clear; writing 0 to a bit leaves it unchanged.
- R10: `irq` is high exactly when some status flag and its enable bit at address 1 are both set.
- R11: Status bit 5, transfer complete, always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sck | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, 0 when not selected |
| irq | output | 1 | Interrupt request |

## Verification
A table of single-word transactions walks the compare logic with 5-, 8-, 12-, 16- and 32-bit frames:
- a hit on value A versus a hit on value B,
- a miss,
- a masked hit versus a masked miss that differs in one unmasked bit,
- a 5-bit word whose compare value has ones above the word width,
- a hit with matching turned off.

Each row also checks the bits shifted both ways. Directed sequences then set the first-word-only mode against a repeated command byte and run a 40-bit frame across a word boundary. They also inject a reply between frames, let the transmit side run dry both at select and mid-transaction, and overfill both FIFOs.

// File: rtl/spi_tgt_match.sv
module spi_tgt_match #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int FLEN_W   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        irq
);
  localparam int WORD_W = 32;
  localparam int WL_W   = $clog2(WORD_W + 1);
  localparam int FR_W   = FLEN_W + 1;
  localparam int TXC_W  = $clog2(TX_DEPTH + 1);
  localparam int RXC_W  = $clog2(RX_DEPTH + 1);
  localparam int TXP_W  = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RXP_W  = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int NF     = 5;
  localparam int F_WORD = 0, F_FRAME = 1, F_TXERR = 2, F_MATCH = 3, F_RXOVF = 4;
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STAT = 3'd2, A_MA = 3'd3,
                         A_MB = 3'd4, A_TX = 3'd5, A_RX = 3'd6;

  function automatic logic [WL_W-1:0] wl_of(input logic [FR_W-1:0] r);
    return (r > FR_W'(WORD_W)) ? WL_W'(WORD_W) : WL_W'(r);
  endfunction

  // host registers
  logic [FLEN_W-1:0] flen;
  logic [1:0]        mmode;
  logic [NF-1:0]     irq_en, flags;
  logic [WORD_W-1:0] match_a, match_b;

  // synchronizers
  logic [2:0] sck_p, cs_p;
  logic [1:0] mosi_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0; cs_p <= '1; mosi_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end

  logic active, cs_fall, sck_rise, sck_fall, mosi_s;
  assign active   = ~cs_p[1];
  assign cs_fall  = ~cs_p[1] & cs_p[2];
  assign sck_rise = active & sck_p[1] & ~sck_p[2];
  assign sck_fall = active & ~sck_p[1] & sck_p[2];
  assign mosi_s   = mosi_p[1];

  // fifos
  logic [WORD_W-1:0] tx_mem [TX_DEPTH];
  logic [WORD_W-1:0] rx_mem [RX_DEPTH];
  logic [TXP_W-1:0]  tx_rp, tx_wp;
  logic [RXP_W-1:0]  rx_rp, rx_wp;
  logic [TXC_W-1:0]  tx_cnt;
  logic [RXC_W-1:0]  rx_cnt;
  logic tx_push, tx_pop, rx_push, rx_pop, tx_empty, rx_full;
  logic [WORD_W-1:0] tx_head;

  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == RXC_W'(RX_DEPTH));
  assign tx_head  = tx_mem[tx_rp];
  assign tx_push  = reg_wr && reg_addr == A_TX && tx_cnt != TXC_W'(TX_DEPTH);
  assign rx_pop   = reg_rd && reg_addr == A_RX && rx_cnt != '0;

  // shift engine state
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_next, wmask;
  logic [FR_W-1:0]   frem, flen_full;
  logic [WL_W-1:0]   wrem, wlen, wl_start;
  logic load_pend, commit_pend, peek_zero, zfr, first_w;
  logic word_end, frame_end, commit, hit_a, hit_b, hit_m, hit;

  assign flen_full = FR_W'(flen) + FR_W'(1);
  assign wl_start  = wl_of(flen_full);
  assign word_end  = sck_rise & (wrem == WL_W'(1));
  assign frame_end = word_end & (frem == FR_W'(1));
  assign commit    = sck_rise & commit_pend;
  assign rx_next   = {rx_sh[WORD_W-2:0], mosi_s};
  assign wmask     = (wlen == WL_W'(WORD_W)) ? '1 : ((WORD_W'(1) << wlen) - WORD_W'(1));
  assign hit_a     = ((rx_next ^ match_a) & wmask) == '0;
  assign hit_b     = ((rx_next ^ match_b) & wmask) == '0;
  assign hit_m     = ((rx_next ^ match_a) & match_b & wmask) == '0;

  always_comb
    case (mmode)
      2'd1:    hit = hit_a | hit_b;
      2'd2:    hit = first_w & (hit_a | hit_b);
      2'd3:    hit = hit_m;
      default: hit = 1'b0;
    endcase

  assign tx_pop  = (cs_fall & ~tx_empty) | (commit & ~peek_zero);
  assign rx_push = word_end & ~rx_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '0; rx_sh <= '0; frem <= '0; wrem <= '0; wlen <= '0;
      load_pend <= 1'b0; commit_pend <= 1'b0; peek_zero <= 1'b0;
      zfr <= 1'b0; first_w <= 1'b0;
    end else if (cs_fall) begin
      frem <= flen_full;
      wrem <= wl_start;
      wlen <= wl_start;
      first_w <= 1'b1;
      rx_sh <= '0;
      load_pend <= 1'b0;
      commit_pend <= 1'b0;
      peek_zero <= 1'b0;
      zfr <= tx_empty;
      tx_sh <= tx_empty ? '0 : (tx_head << (WL_W'(WORD_W) - wl_start));
    end else if (sck_rise) begin
      rx_sh <= rx_next;
      commit_pend <= 1'b0;
      if (commit && peek_zero) zfr <= 1'b1;
      if (word_end) begin
        rx_sh <= '0;
        first_w <= 1'b0;
        load_pend <= 1'b1;
        if (frame_end) begin
          frem <= flen_full;
          wrem <= wl_start;
          wlen <= wl_start;
          zfr <= 1'b0;
        end else begin
          frem <= frem - FR_W'(1);
          wrem <= wl_of(frem - FR_W'(1));
          wlen <= wl_of(frem - FR_W'(1));
        end
      end else begin
        wrem <= wrem - WL_W'(1);
        frem <= frem - FR_W'(1);
      end
    end else if (sck_fall) begin
      if (load_pend) begin
        load_pend <= 1'b0;
        commit_pend <= 1'b1;
        peek_zero <= zfr | tx_empty;
        tx_sh <= (zfr | tx_empty) ? '0 : (tx_head << (WL_W'(WORD_W) - wlen));
      end else begin
        tx_sh <= tx_sh << 1;
      end
    end

  assign miso = active & tx_sh[WORD_W-1];

  // fifo storage
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) begin
        tx_mem[tx_wp] <= reg_wdata;
        tx_wp <= (tx_wp == TXP_W'(TX_DEPTH - 1)) ? '0 : tx_wp + TXP_W'(1);
      end
      if (tx_pop) tx_rp <= (tx_rp == TXP_W'(TX_DEPTH - 1)) ? '0 : tx_rp + TXP_W'(1);
      tx_cnt <= tx_cnt + TXC_W'(tx_push) - TXC_W'(tx_pop);
      if (rx_push) begin
        rx_mem[rx_wp] <= rx_next;
        rx_wp <= (rx_wp == RXP_W'(RX_DEPTH - 1)) ? '0 : rx_wp + RXP_W'(1);
      end
      if (rx_pop) rx_rp <= (rx_rp == RXP_W'(RX_DEPTH - 1)) ? '0 : rx_rp + RXP_W'(1);
      rx_cnt <= rx_cnt + RXC_W'(rx_push) - RXC_W'(rx_pop);
    end

  // registers and flags
  logic [NF-1:0] fset, fclr;
  always_comb begin
    fset = '0;
    fset[F_WORD]  = word_end;
    fset[F_FRAME] = frame_end;
    fset[F_TXERR] = (cs_fall & tx_empty) | (commit & peek_zero & ~zfr);
    fset[F_MATCH] = word_end & hit;
    fset[F_RXOVF] = word_end & rx_full;
  end
  assign fclr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NF-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flen <= FLEN_W'(7); mmode <= '0; irq_en <= '0; flags <= '0;
      match_a <= '0; match_b <= '0;
    end else begin
      flags <= (flags & ~fclr) | fset;
      if (reg_wr)
        case (reg_addr)
          A_CTRL: begin flen <= reg_wdata[FLEN_W-1:0]; mmode <= reg_wdata[9:8]; end
          A_IEN:  irq_en <= reg_wdata[NF-1:0];
          A_MA:   match_a <= reg_wdata;
          A_MB:   match_b <= reg_wdata;
          default: ;
        endcase
    end

  assign irq = |(flags & irq_en);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin reg_rdata[FLEN_W-1:0] = flen; reg_rdata[9:8] = mmode; end
      A_IEN:  reg_rdata[NF-1:0] = irq_en;
      A_STAT: begin
        reg_rdata[NF-1:0] = flags;
        reg_rdata[8 +: TXC_W] = tx_cnt;
        reg_rdata[16 +: RXC_W] = rx_cnt;
      end
      A_MA:   reg_rdata = match_a;
      A_MB:   reg_rdata = match_b;
      A_RX:   reg_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
      default: ;
    endcase
  end
endmodule

module spi_tgt_match_chk #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int TXC_W = 3,
  parameter int RXC_W = 3
) (
  input logic clk, rst_n, active, tx_push, tx_pop, rx_pop,
  input logic word_end, frame_end, irq, reg_wr,
  input logic [2:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic [4:0] flags,
  input logic [TXC_W-1:0] tx_cnt,
  input logic [RXC_W-1:0] rx_cnt
);
  a_r3_tx_bound: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= TXC_W'(TX_DEPTH));
  a_r8_rx_bound: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= RXC_W'(RX_DEPTH));
  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_pop) |=> tx_cnt == $past(tx_cnt) + TXC_W'(1));
  a_r3_pop_selected: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> active);
  a_r5_frame_on_word: assert property (@(posedge clk) disable iff (!rst_n) frame_end |-> word_end);
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == RXC_W'(RX_DEPTH) && !rx_pop) |=> rx_cnt == RXC_W'(RX_DEPTH));
  a_r9_match_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3] && !(reg_wr && reg_addr == 3'd2 && reg_wdata[3])) |=> flags[3]);
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n) irq |-> flags != '0);
endmodule

bind spi_tgt_match spi_tgt_match_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TXC_W(TXC_W), .RXC_W(RXC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .active(active), .tx_push(tx_push), .tx_pop(tx_pop),
  .rx_pop(rx_pop), .word_end(word_end), .frame_end(frame_end), .irq(irq),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flags(flags),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_tgt_match_tb.sv
module spi_tgt_match_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, sck = 0, cs_n = 1, mosi = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic miso, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  spi_tgt_match dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [5:0]  fl;
    logic [1:0]  mm;
    logic [31:0] ma, mb, tx, rx;
    logic        hit;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{6'd7,  2'd1, 32'hA5, 32'h3C, 32'h5A, 32'hA5, 1'b1},
    '{6'd7,  2'd1, 32'hA5, 32'h3C, 32'h81, 32'h3C, 1'b1},
    '{6'd7,  2'd1, 32'hA5, 32'h3C, 32'hFF, 32'h11, 1'b0},
    '{6'd15, 2'd3, 32'h1200, 32'hFF00, 32'hBEEF, 32'h12AB, 1'b1},
    '{6'd15, 2'd3, 32'h1200, 32'hFF00, 32'h0001, 32'h13AB, 1'b0},
    '{6'd31, 2'd0, 32'hDEADBEEF, 32'h0, 32'hCAFEF00D, 32'hDEADBEEF, 1'b0},
    '{6'd4,  2'd1, 32'hF5, 32'h0, 32'h0A, 32'h15, 1'b1},
    '{6'd11, 2'd2, 32'hABC, 32'h0, 32'h123, 32'hABC, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, input bit pop, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = pop;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_hi();
    if (sck) begin sck = 0; repeat (HP) @(negedge clk); end
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic shift(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sck = 0;
      mosi = din[i];
      repeat (HP) @(negedge clk);
      sck = 1;
      dout[i] = miso;
      repeat (HP) @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] got;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    reg_read(2, 0, d); chk("R1 status", d, 0);
    reg_read(0, 0, d); chk("R1 ctrl", d, 32'h7);
    chk("R1 miso", miso, 0);
    chk("R1 irq", irq, 0);

    // table: R2 shifting, R6 compare, R5 flags
    for (int k = 0; k < NV; k++) begin
      reg_write(2, 32'h1F);
      reg_write(0, {22'b0, VEC[k].mm, 2'b0, VEC[k].fl});
      reg_write(3, VEC[k].ma);
      reg_write(4, VEC[k].mb);
      reg_write(5, VEC[k].tx);
      cs_lo();
      shift(int'(VEC[k].fl) + 1, {32'b0, VEC[k].rx}, got);
      cs_hi();
      chk("R2 miso bits", got, {32'b0, VEC[k].tx});
      reg_read(6, 1, d); chk("R2 rx word", d, VEC[k].rx);
      reg_read(2, 0, d); chk("R6 status", d[5:0], {2'b00, VEC[k].hit, 3'b011});
    end

    // R3 depth, order, remaining count; R4 underrun at select; R8 overflow
    reg_write(2, 32'h1F);
    reg_write(0, 32'h7);
    for (int i = 1; i <= 5; i++) reg_write(5, 32'(i * 8'h11));
    reg_read(2, 0, d); chk("R3 tx level full", d[10:8], 3'd4);
    cs_lo();
    for (int f = 0; f < 4; f++) begin
      shift(8, 64'(8'hA0 + f), got);
      chk("R3 tx order", got, 64'((f + 1) * 8'h11));
      if (f == 0) begin reg_read(2, 0, d); chk("R3 remaining", d[10:8], 3'd3); end
    end
    cs_hi();
    reg_read(2, 0, d); chk("R3 tx drained", d[10:8], 3'd0);
    cs_lo();
    shift(8, 64'h99, got);
    cs_hi();
    chk("R4 zero data", got, 0);
    reg_read(2, 0, d);
    chk("R4 txerr", d[2], 1);
    chk("R8 overflow", d[4], 1);
    chk("R11 no xfer done", d[5], 0);
    for (int f = 0; f < 4; f++) begin
      reg_read(6, 1, d); chk("R8 kept words", d, 32'(8'hA0 + f));
    end
    reg_read(2, 0, d); chk("R8 rx empty", d[18:16], 3'd0);

    // R9 writing zero keeps flags, ones clear
    reg_write(2, 32'h0);
    reg_read(2, 0, d); chk("R9 zero write", d[4:0], 5'h17);
    reg_write(2, 32'h1F);
    reg_read(2, 0, d); chk("R9 cleared", d[4:0], 5'h0);

    // R5 40-bit frame split into 32 + 8
    reg_write(0, 32'd39);
    reg_write(5, 32'h89ABCDEF);
    reg_write(5, 32'hC3);
    cs_lo();
    shift(32, 64'hF0123456, got);
    chk("R5 first word out", got, 64'h89ABCDEF);
    reg_read(2, 0, d); chk("R5 word not frame", d[1:0], 2'b01);
    reg_write(2, 32'h3);
    shift(8, 64'h78, got);
    cs_hi();
    chk("R5 last word out", got, 64'hC3);
    reg_read(2, 0, d); chk("R5 frame done", d[2:0], 3'b011);
    reg_read(6, 1, d); chk("R5 rx word 0", d, 32'hF0123456);
    reg_read(6, 1, d); chk("R5 rx word 1", d, 32'h78);

    // R6 first-word-only mode
    reg_write(2, 32'h1F);
    reg_write(0, 32'h207);
    reg_write(3, 32'h42);
    reg_write(4, 32'h0);
    reg_write(5, 32'h1);
    reg_write(5, 32'h2);
    cs_lo();
    shift(8, 64'h42, got);
    reg_read(2, 0, d); chk("R6 first word hit", d[3], 1);
    reg_write(2, 32'h8);
    shift(8, 64'h42, got);
    cs_hi();
    reg_read(2, 0, d); chk("R6 later word ignored", d[3], 0);
    reg_read(6, 1, d); reg_read(6, 1, d);

    // R7 reply injection, R10 interrupt, R4 mid-transaction underrun
    reg_write(2, 32'h1F);
    reg_write(0, 32'h107);
    reg_write(3, 32'hC7);
    reg_write(1, 32'h8);
    reg_write(5, 32'h01);
    cs_lo();
    shift(8, 64'hC7, got);
    chk("R2 first reply", got, 64'h01);
    chk("R10 irq on match", irq, 1);
    reg_write(2, 32'h8);
    chk("R10 irq cleared", irq, 0);
    reg_write(5, 32'hE4);
    shift(8, 64'h10, got);
    chk("R7 injected reply", got, 64'hE4);
    reg_read(2, 0, d); chk("R7 no underrun", d[2], 0);
    shift(8, 64'h11, got);
    cs_hi();
    chk("R4 mid zero data", got, 0);
    reg_read(2, 0, d); chk("R4 mid txerr", d[2], 1);
    chk("R10 masked flags", irq, 0);
    reg_write(1, 32'h4);
    chk("R10 txerr enabled", irq, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule